// File: doc/BRIEF.md
# Video Status and Beam Position Register Port

This block is the register-read side of a video display controller that sits on an 8-bit processor bus. It holds a status byte and a collision byte, and it keeps two beam position bytes that are either live or frozen. It drives the processor's frame interrupt line and an "inside the picture" test level. The horizontal and vertical beam counters come from an external timing generator. An end-of-frame pulse also comes from outside, and so do the collision hit bits from the collision detector. Rendering, collision detection and sound are outside this block.

The processor reaches the block through one-cycle read and write strobes with an 8-bit offset. Read data is combinational and reflects the state before the clock edge that ends the strobe. Side effects of a read, such as clearing or latching, take effect at that edge. No stream data passes through the block, so there is no valid/ready handshake and no back-pressure. Every access completes in the cycle it is presented. Offsets that have no special meaning fall through to a plain 256-byte register file. The beam strobe control bit lives at offset 0xA0, bit 1.

Top module: `vdc_status_port`

## Requirements
- R1: After reset, irq is 0, the status, collision and both beam latches are 0, and every register file byte is 0.
- R2: A read at offset 0xA1 returns the status byte. Bit 0 of the returned byte is forced to 1 while hpos < ACT_START or hpos > ACT_END. At the ending edge, the read clears the pending interrupt (irq falls) and clears status bit 3. Stored status bit 0 is only cleared by reset.
- R3: A read at offset 0xA2 returns the collision byte and clears it at the ending edge. coll_set bits are ORed into the byte every cycle, and a bit set in the same cycle as the clearing read survives.
- R4: A read at offset 0xA4 returns Y = (vpos − VIS_FIRST) mod 256. While control bit 1 (offset 0xA0) is 1, the value is live and is also stored in the Y latch. While that bit is 0, the read returns the Y latch.
- R5: A read at offset 0xA5 returns X, which is hpos − ACT_START when hpos ≥ ACT_START and hpos − ACT_START + LINE_LEN otherwise, taken mod 256. X is live with strobe set and latched with strobe clear, as in R4.
- R6: A write at offset 0xA0 that takes control bit 1 from 1 to 0 captures the current X and Y into the latches. No other write or non-strobed read changes them.
- R7: A frame_end pulse sets status bit 3 and raises irq on the next edge. If frame_end coincides with a 0xA1 read, the set wins.
- R8: Status bit 0 is set when hpos equals ACT_END + HBLANK_DELAY and VIS_FIRST − 1 ≤ vpos < VBLANK_START − 1.
- R9: disp_active is 1 exactly when VIS_FIRST < vpos < VBLANK_START and ACT_START ≤ hpos < ACT_END.
- R10: Every write stores its byte in the register file. A read at any offset other than 0xA1, 0xA2, 0xA4 and 0xA5 returns the stored byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | HW | Horizontal beam counter |
| vpos | input | HW | Vertical beam counter |
| frame_end | input | 1 | One-cycle pulse at the end of the visible frame |
| coll_set | input | 8 | Collision hit bits to accumulate |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational) |
| irq | output | 1 | Frame interrupt to the processor, active high |
| disp_active | output | 1 | High while the beam is inside the displayed picture |

## Verification
The bench goes after the edges of the horizontal re-base: hpos one below the active start, exactly at it, and at the line end. A wrong wrap there gives a small negative value instead of a value near the line length. It checks the strict bounds of the active test and of the outside-window status bit, where an off-by-one lights the bit one clock early or late. It checks strobe capture, including a second clearing write that must not re-capture, and a design that latches on any control write would move the frozen values. It also drives the end-of-frame pulse and the collision hit bits in the same cycle as the clearing reads; a design with the wrong priority drops an interrupt or a hit.

// File: rtl/vsp_pkg.sv
package vsp_pkg;
  localparam logic [7:0] OFS_CTRL   = 8'hA0;
  localparam logic [7:0] OFS_STAT   = 8'hA1;
  localparam logic [7:0] OFS_COLL   = 8'hA2;
  localparam logic [7:0] OFS_BEAM_Y = 8'hA4;
  localparam logic [7:0] OFS_BEAM_X = 8'hA5;

  // horizontal re-base with wrap through the line length
  function automatic logic [7:0] rebase_x(input int h, input int start, input int len);
    int t;
    t = (h < start) ? (h - start + len) : (h - start);
    return 8'(t);
  endfunction

  function automatic logic [7:0] rebase_y(input int v, input int first);
    return 8'(v - first);
  endfunction
endpackage

// File: rtl/vsp_beam.sv
module vsp_beam
  import vsp_pkg::*;
#(
  parameter int HW        = 9,
  parameter int ACT_START = 16,
  parameter int LINE_LEN  = 228,
  parameter int VIS_FIRST = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hpos,
  input  logic [HW-1:0] vpos,
  input  logic          cap_x,
  input  logic          cap_y,
  output logic [7:0]    live_x,
  output logic [7:0]    live_y,
  output logic [7:0]    x_q,
  output logic [7:0]    y_q
);
  always_comb begin
    live_x = rebase_x(int'(hpos), ACT_START, LINE_LEN);
    live_y = rebase_y(int'(vpos), VIS_FIRST);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
    end else begin
      if (cap_x) x_q <= live_x;
      if (cap_y) y_q <= live_y;
    end
  end
endmodule

// File: rtl/vsp_status.sv
module vsp_status #(
  parameter int HW           = 9,
  parameter int ACT_END      = 176,
  parameter int HBLANK_DELAY = 18,
  parameter int VIS_FIRST    = 24,
  parameter int VBLANK_START = 264
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hpos,
  input  logic [HW-1:0] vpos,
  input  logic          frame_end,
  input  logic [7:0]    coll_set,
  input  logic          rd_stat,
  input  logic          rd_coll,
  output logic [7:0]    stat_q,
  output logic [7:0]    coll_q,
  output logic          irq
);
  localparam int HB_POS = ACT_END + HBLANK_DELAY;
  localparam int V_LO   = VIS_FIRST - 1;
  localparam int V_HI   = VBLANK_START - 1;

  logic vbl_q, hbl_q, pend_q, hb_hit;

  assign hb_hit = (int'(hpos) == HB_POS) && (int'(vpos) >= V_LO) && (int'(vpos) < V_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vbl_q  <= 1'b0;
      hbl_q  <= 1'b0;
      pend_q <= 1'b0;
      coll_q <= '0;
    end else begin
      // clear by read first, frame end overrides
      if (frame_end) begin
        vbl_q  <= 1'b1;
        pend_q <= 1'b1;
      end else if (rd_stat) begin
        vbl_q  <= 1'b0;
        pend_q <= 1'b0;
      end
      if (hb_hit) hbl_q <= 1'b1;
      coll_q <= (rd_coll ? 8'h00 : coll_q) | coll_set;
    end
  end

  assign stat_q = {4'b0000, vbl_q, 2'b00, hbl_q};
  assign irq    = pend_q;
endmodule

// File: rtl/vsp_regs.sv
module vsp_regs #(
  parameter int DEPTH = 256,
  parameter int DW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/vdc_status_port.sv
module vdc_status_port
  import vsp_pkg::*;
#(
  parameter int HW           = 9,
  parameter int LINE_LEN     = 228,
  parameter int ACT_START    = 16,
  parameter int ACT_END      = 176,
  parameter int HBLANK_DELAY = 18,
  parameter int VIS_FIRST    = 24,
  parameter int VBLANK_START = 264,
  parameter int STROBE_BIT   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] hpos,
  input  logic [HW-1:0] vpos,
  input  logic          frame_end,
  input  logic [7:0]    coll_set,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [7:0]    addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          irq,
  output logic          disp_active
);
  localparam int REG_DEPTH = 256;

  logic       strobe_q;
  logic       rd_stat, rd_coll, rd_y, rd_x, wr_ctrl, cap_x, cap_y, outside;
  logic [7:0] stat_q, coll_q, live_x, live_y, x_q, y_q, file_rd;

  assign rd_stat = rd_en && (addr == OFS_STAT);
  assign rd_coll = rd_en && (addr == OFS_COLL);
  assign rd_y    = rd_en && (addr == OFS_BEAM_Y);
  assign rd_x    = rd_en && (addr == OFS_BEAM_X);
  assign wr_ctrl = wr_en && (addr == OFS_CTRL);

  // capture on falling strobe, or track on live reads
  assign cap_x = (wr_ctrl && strobe_q && !wdata[STROBE_BIT]) || (rd_x && strobe_q);
  assign cap_y = (wr_ctrl && strobe_q && !wdata[STROBE_BIT]) || (rd_y && strobe_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       strobe_q <= 1'b0;
    else if (wr_ctrl) strobe_q <= wdata[STROBE_BIT];
  end

  vsp_beam #(
    .HW(HW), .ACT_START(ACT_START), .LINE_LEN(LINE_LEN), .VIS_FIRST(VIS_FIRST)
  ) u_beam (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
    .cap_x(cap_x), .cap_y(cap_y),
    .live_x(live_x), .live_y(live_y), .x_q(x_q), .y_q(y_q)
  );

  vsp_status #(
    .HW(HW), .ACT_END(ACT_END), .HBLANK_DELAY(HBLANK_DELAY),
    .VIS_FIRST(VIS_FIRST), .VBLANK_START(VBLANK_START)
  ) u_stat (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos),
    .frame_end(frame_end), .coll_set(coll_set),
    .rd_stat(rd_stat), .rd_coll(rd_coll),
    .stat_q(stat_q), .coll_q(coll_q), .irq(irq)
  );

  vsp_regs #(.DEPTH(REG_DEPTH), .DW(8)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_en), .waddr(addr), .wdata(wdata),
    .raddr(addr), .rdata(file_rd)
  );

  assign outside = (int'(hpos) < ACT_START) || (int'(hpos) > ACT_END);

  always_comb begin
    unique case (addr)
      OFS_STAT:   rdata = stat_q | {7'b0, outside};
      OFS_COLL:   rdata = coll_q;
      OFS_BEAM_Y: rdata = strobe_q ? live_y : y_q;
      OFS_BEAM_X: rdata = strobe_q ? live_x : x_q;
      default:    rdata = file_rd;
    endcase
  end

  assign disp_active = (int'(vpos) > VIS_FIRST) && (int'(vpos) < VBLANK_START) &&
                       (int'(hpos) >= ACT_START) && (int'(hpos) < ACT_END);
endmodule

// File: rtl/vsp_checker.sv
module vsp_checker #(
  parameter int HW      = 9,
  parameter int ACT_END = 176
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hpos,
  input logic          frame_end,
  input logic [7:0]    coll_set,
  input logic          rd_en,
  input logic          wr_en,
  input logic [7:0]    addr,
  input logic          irq,
  input logic          disp_active,
  input logic [7:0]    coll_q,
  input logic [7:0]    y_q
);
  a_r2_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'hA1 && !frame_end) |=> !irq);

  a_r7_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> irq);

  a_r7_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_end && !irq) |=> !irq);

  a_r3_coll_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'hA2 && coll_set == 8'h00) |=> (coll_q == 8'h00));

  a_r6_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && addr == 8'hA0) && !(rd_en && addr == 8'hA4)) |=> $stable(y_q));

  a_r9_dark_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(hpos) >= ACT_END) |-> !disp_active);
endmodule

bind vdc_status_port vsp_checker #(.HW(HW), .ACT_END(ACT_END)) u_chk (
  .clk(clk), .rst_n(rst_n), .hpos(hpos), .frame_end(frame_end),
  .coll_set(coll_set), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
  .irq(irq), .disp_active(disp_active), .coll_q(coll_q), .y_q(y_q)
);

// File: tb/sim_vdc_status_port.sv
module sim_vdc_status_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] hpos = 9'd100, vpos = 9'd40;
  logic       frame_end = 1'b0;
  logic [7:0] coll_set = 8'h00;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq, disp_active;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vdc_status_port u0 (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .vpos(vpos), .frame_end(frame_end),
    .coll_set(coll_set), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .disp_active(disp_active)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d (0x%0h) expected %0d (0x%0h)", tag, got, got, exp, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    @(negedge clk); #1;
    check("R1 irq after reset", irq, 0);
    rd(8'hA1, d); check("R1 status after reset", d, 8'h00);
    rd(8'hA5, d); check("R1 X latch after reset", d, 0);
    rd(8'hA4, d); check("R1 Y latch after reset", d, 0);
    rd(8'h10, d); check("R1 file byte after reset", d, 0);
  endtask

  task automatic t_active;
    int hv [6][3] = '{'{100,40,1}, '{176,40,0}, '{15,40,0}, '{16,25,1}, '{100,24,0}, '{100,263,1}};
    foreach (hv[i]) begin
      @(negedge clk); hpos = 9'(hv[i][0]); vpos = 9'(hv[i][1]);
      #1 check($sformatf("R9 active h=%0d v=%0d", hv[i][0], hv[i][1]), disp_active, hv[i][2]);
    end
    @(negedge clk); vpos = 9'd264; #1 check("R9 active at blank start", disp_active, 0);
    vpos = 9'd40; hpos = 9'd100;
  endtask

  task automatic t_outside_bit;
    logic [7:0] d;
    hpos = 9'd176; rd(8'hA1, d); check("R2 bit0 at window end", d, 8'h00);
    hpos = 9'd177; rd(8'hA1, d); check("R2 bit0 past window end", d, 8'h01);
    hpos = 9'd15;  rd(8'hA1, d); check("R2 bit0 before window", d, 8'h01);
    hpos = 9'd100;
  endtask

  task automatic t_frame_irq;
    logic [7:0] d;
    @(negedge clk); frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
    check("R7 irq raised", irq, 1);
    rd(8'hA1, d); check("R7 status bit3 set", d, 8'h08);
    check("R2 irq cleared by read", irq, 0);
    rd(8'hA1, d); check("R2 bit3 cleared", d, 8'h00);
    @(negedge clk); frame_end = 1'b1; @(negedge clk); frame_end = 1'b0;
    @(negedge clk); addr = 8'hA1; rd_en = 1'b1; frame_end = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; frame_end = 1'b0;
    check("R7 collide read value", d, 8'h08);
    check("R7 set wins over read", irq, 1);
    rd(8'hA1, d); check("R7 bit3 kept", d, 8'h08);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    @(negedge clk); coll_set = 8'h05; @(negedge clk); coll_set = 8'h00;
    rd(8'hA2, d); check("R3 collision value", d, 8'h05);
    rd(8'hA2, d); check("R3 cleared after read", d, 8'h00);
    @(negedge clk); addr = 8'hA2; rd_en = 1'b1; coll_set = 8'h20;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0; coll_set = 8'h00;
    check("R3 read during hit", d, 8'h00);
    rd(8'hA2, d); check("R3 hit survives clear", d, 8'h20);
  endtask

  task automatic t_live;
    logic [7:0] d;
    wr(8'hA0, 8'h02);
    vpos = 9'd40; rd(8'hA4, d); check("R4 live Y", d, 16);
    vpos = 9'd10; rd(8'hA4, d); check("R4 live Y negative", d, 242);
    hpos = 9'd100; rd(8'hA5, d); check("R5 X mid line", d, 84);
    hpos = 9'd16;  rd(8'hA5, d); check("R5 X at start", d, 0);
    hpos = 9'd15;  rd(8'hA5, d); check("R5 X wrap one before", d, 227);
    hpos = 9'd5;   rd(8'hA5, d); check("R5 X wrap", d, 217);
    hpos = 9'd227; rd(8'hA5, d); check("R5 X line end", d, 211);
  endtask

  task automatic t_capture;
    logic [7:0] d;
    hpos = 9'd50; vpos = 9'd30;
    wr(8'hA0, 8'h00);
    hpos = 9'd120; vpos = 9'd100;
    rd(8'hA5, d); check("R6 captured X", d, 34);
    rd(8'hA4, d); check("R6 captured Y", d, 6);
    wr(8'hA0, 8'h00);
    rd(8'hA5, d); check("R6 no recapture X", d, 34);
    rd(8'hA0, d); check("R10 control readback", d, 8'h00);
    hpos = 9'd100; vpos = 9'd40;
  endtask

  task automatic t_file;
    logic [7:0] d;
    wr(8'h10, 8'h33); wr(8'hFF, 8'hCC); wr(8'h00, 8'h5A);
    rd(8'h10, d); check("R10 file 0x10", d, 8'h33);
    rd(8'hFF, d); check("R10 file 0xFF", d, 8'hCC);
    rd(8'h00, d); check("R10 file 0x00", d, 8'h5A);
  endtask

  task automatic t_hblank;
    logic [7:0] d;
    @(negedge clk); hpos = 9'd194; vpos = 9'd263;
    @(negedge clk); vpos = 9'd22;
    @(negedge clk); hpos = 9'd100; vpos = 9'd40;
    rd(8'hA1, d); check("R8 no set outside lines", d, 8'h00);
    @(negedge clk); hpos = 9'd194; vpos = 9'd23;
    @(negedge clk); hpos = 9'd100; vpos = 9'd40;
    rd(8'hA1, d); check("R8 bit0 set", d, 8'h01);
    rd(8'hA1, d); check("R2 bit0 sticky", d, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_active();
    t_outside_bit();
    t_frame_irq();
    t_collision();
    t_live();
    t_capture();
    t_file();
    t_hblank();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule